// File: doc/BRIEF.md
# Video RAM Transfer Cycle Sequencer

This block runs transfer cycles between the random-access array of a dual-port video RAM and its serial shift register. A host asks for a read transfer, which loads a row into the shift register, or a write transfer, which stores the shift register into a row. The block then drives the row strobe, the column strobe, the transfer/output-enable strobe, the write strobe and the serial output enable through a fixed sequence of phases. Each phase lasts a parameterised number of clocks.

The block remembers which way the serial I/O lines currently point. A read transfer leaves them driving out. A write transfer needs them as inputs. When a write is requested while the port is still in output mode, the block first runs a pseudo write transfer, which has write-transfer signalling but keeps the serial output enable negated. This turns the serial lines around without moving data. The real write follows at once, and the host sees one acknowledge for the pair.

Outside a transfer, a window request input controls the transfer/output-enable strobe directly. From the start of a transfer until the column strobe rises, the window request is masked. The host port is valid/ready. The block raises `req_ready` only while idle, which means only after the precharge of the previous cycle has ended. A request presented earlier is back-pressured: the host must hold `req_valid` and `req_write` steady until the clock edge where both valid and ready are high. `xfer_done` pulses once when the last cycle of an accepted request finishes its precharge.

Top module: `vxfer_seq`

## Requirements
- R1: After reset the strobes `ras_n`, `cas_n`, `we_n` and `soe_n` are high, `xfer_cyc`, `par_hiz`, `xfer_done` and `ser_out` are low, and `req_ready` is high.
- R2: Every cycle runs four phases in order. Setup lasts T_SETUP clocks, with `dtoe_n` low and `ras_n` high. Row lasts T_RCD clocks, with `ras_n` low. Column lasts T_CAS clocks, with `ras_n` and `cas_n` low. Precharge lasts T_PRE clocks, with both strobes high. `dtoe_n` is therefore low in the clock before `ras_n` falls.
- R3: In a read or write transfer, `soe_n` is low for all of setup, row and column. `we_n` stays high in a read transfer. `we_n` is low in those three phases of a write transfer and of a pseudo write transfer.
- R4: `par_hiz` is high exactly during the setup, row and column phases of a read transfer.
- R5: `ser_out` (1 = serial port in output mode) resets to 0. It becomes 1 when a read transfer's column phase ends, and 0 when a write or pseudo write column phase ends.
- R6: A write request accepted while `ser_out` is 1 runs first a pseudo write cycle with `soe_n` held high, then a real write cycle, giving two row strobes in total.
- R7: A write request accepted while `ser_out` is 0, and any read request, runs exactly one cycle.
- R8: While `xfer_cyc` is high, `dtoe_n` is 0 whatever `win_req` does. At all other times `dtoe_n` equals the inverse of `win_req`.
- R9: `req_ready` is high only when idle, and a request is taken when `req_valid` and `req_ready` are both high at a clock edge. `xfer_done` is a one-clock pulse in the last precharge clock of the request, and `req_ready` is high in the next clock. With default timing the request-to-done span is 12 clocks, or 24 when a pseudo cycle is added.
- R10: `xfer_cyc` is high exactly during the setup, row and column phases of every cycle, including pseudo cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Host transfer request valid |
| req_write | input | 1 | 1 = write transfer, 0 = read transfer; held with req_valid |
| req_ready | output | 1 | Block is idle and will take a request |
| xfer_done | output | 1 | One-clock acknowledge at the end of the request |
| win_req | input | 1 | Window request for the output enable, active high |
| ras_n | output | 1 | Row address strobe, active low |
| cas_n | output | 1 | Column address strobe, active low |
| dtoe_n | output | 1 | Transfer / output-enable strobe, active low |
| we_n | output | 1 | Write strobe, active low |
| soe_n | output | 1 | Serial output enable, active low |
| xfer_cyc | output | 1 | Transfer qualifier, high during the active phases |
| par_hiz | output | 1 | Parallel data bus must be tri-stated (read transfer) |
| ser_out | output | 1 | Serial I/O direction, 1 = output mode |

## Verification
The bench targets a write that follows a read. A design that skipped the pseudo cycle would show one row strobe instead of two. A design that kept the serial enable low in the pseudo cycle would let the shift register overwrite a row. It also toggles the window request in every clock of a transfer: a leaky mask would release the transfer strobe before the column strobe rises. A request held while the block is busy checks that nothing is taken before precharge ends, and back-to-back write, read and write sequences check that the direction register flips only at column-phase ends.

// File: rtl/vxfer_pkg.sv
`timescale 1ns/1ps
package vxfer_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_SETUP = 3'd1,
    PH_RAS   = 3'd2,
    PH_CAS   = 3'd3,
    PH_PRE   = 3'd4
  } phase_t;

  typedef enum logic [1:0] {
    XK_READ   = 2'd0,
    XK_WRITE  = 2'd1,
    XK_PSEUDO = 2'd2
  } kind_t;

  function automatic logic phase_active(input phase_t p);
    return (p == PH_SETUP) || (p == PH_RAS) || (p == PH_CAS);
  endfunction

endpackage

// File: rtl/vxfer_phase_timer.sv
`timescale 1ns/1ps
// Down-counter for phase length; last is high in the final clock of a phase.
module vxfer_phase_timer #(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          last
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (load)          cnt <= load_val;
    else if (cnt != '0)     cnt <= cnt - 1'b1;
  end

  assign last = (cnt == '0);
endmodule

// File: rtl/vxfer_dir_track.sv
`timescale 1ns/1ps
// Serial port direction: 1 = output mode, 0 = input mode.
module vxfer_dir_track (
  input  logic clk,
  input  logic rst_n,
  input  logic upd,
  input  logic to_out,
  output logic dir_out
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   dir_out <= 1'b0;
    else if (upd) dir_out <= to_out;
  end
endmodule

// File: rtl/vxfer_pin_gen.sv
`timescale 1ns/1ps
// Strobe decode from the registered phase and cycle kind.
module vxfer_pin_gen
  import vxfer_pkg::*;
(
  input  phase_t ph,
  input  kind_t  kind,
  input  logic   win_req,
  output logic   ras_n,
  output logic   cas_n,
  output logic   dtoe_n,
  output logic   we_n,
  output logic   soe_n,
  output logic   xfer_cyc,
  output logic   par_hiz
);
  logic act;

  always_comb begin
    act      = phase_active(ph);
    xfer_cyc = act;
    ras_n    = !((ph == PH_RAS) || (ph == PH_CAS));
    cas_n    = !(ph == PH_CAS);
    // window masked from transfer start until the column strobe rises
    dtoe_n   = act ? 1'b0 : !win_req;
    we_n     = !(act && (kind != XK_READ));
    soe_n    = !(act && (kind != XK_PSEUDO));
    par_hiz  = act && (kind == XK_READ);
  end
endmodule

// File: rtl/vxfer_seq.sv
`timescale 1ns/1ps
module vxfer_seq
  import vxfer_pkg::*;
#(
  parameter int T_SETUP = 2,
  parameter int T_RCD   = 3,
  parameter int T_CAS   = 3,
  parameter int T_PRE   = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic req_write,
  output logic req_ready,
  output logic xfer_done,
  input  logic win_req,
  output logic ras_n,
  output logic cas_n,
  output logic dtoe_n,
  output logic we_n,
  output logic soe_n,
  output logic xfer_cyc,
  output logic par_hiz,
  output logic ser_out
);
  localparam int TMAX01 = (T_SETUP > T_RCD) ? T_SETUP : T_RCD;
  localparam int TMAX23 = (T_CAS > T_PRE) ? T_CAS : T_PRE;
  localparam int TMAX   = (TMAX01 > TMAX23) ? TMAX01 : TMAX23;
  localparam int CW     = $clog2(TMAX + 1);

  phase_t        ph, ph_nx;
  kind_t         kind, kind_nx;
  logic          pend, pend_nx;
  logic          adv, last;
  logic [CW-1:0] len_nx;

  assign req_ready = (ph == PH_IDLE);

  always_comb begin
    ph_nx   = ph;
    kind_nx = kind;
    pend_nx = pend;
    adv     = 1'b0;
    case (ph)
      PH_IDLE: if (req_valid) begin
        adv     = 1'b1;
        ph_nx   = PH_SETUP;
        pend_nx = req_write && ser_out;
        if (req_write) kind_nx = ser_out ? XK_PSEUDO : XK_WRITE;
        else           kind_nx = XK_READ;
      end
      PH_SETUP: if (last) begin adv = 1'b1; ph_nx = PH_RAS; end
      PH_RAS:   if (last) begin adv = 1'b1; ph_nx = PH_CAS; end
      PH_CAS:   if (last) begin adv = 1'b1; ph_nx = PH_PRE; end
      PH_PRE: if (last) begin
        adv = 1'b1;
        if (pend) begin
          ph_nx   = PH_SETUP;
          kind_nx = XK_WRITE;
          pend_nx = 1'b0;
        end else begin
          ph_nx   = PH_IDLE;
        end
      end
      default: ph_nx = PH_IDLE;
    endcase
  end

  always_comb begin
    case (ph_nx)
      PH_SETUP: len_nx = CW'(T_SETUP - 1);
      PH_RAS:   len_nx = CW'(T_RCD - 1);
      PH_CAS:   len_nx = CW'(T_CAS - 1);
      PH_PRE:   len_nx = CW'(T_PRE - 1);
      default:  len_nx = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph   <= PH_IDLE;
      kind <= XK_READ;
      pend <= 1'b0;
    end else begin
      ph   <= ph_nx;
      kind <= kind_nx;
      pend <= pend_nx;
    end
  end

  assign xfer_done = (ph == PH_PRE) && last && !pend;

  vxfer_phase_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (adv),
    .load_val (len_nx),
    .last     (last)
  );

  vxfer_dir_track u_dir (
    .clk     (clk),
    .rst_n   (rst_n),
    .upd     ((ph == PH_CAS) && last),
    .to_out  (kind == XK_READ),
    .dir_out (ser_out)
  );

  vxfer_pin_gen u_pins (
    .ph       (ph),
    .kind     (kind),
    .win_req  (win_req),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .dtoe_n   (dtoe_n),
    .we_n     (we_n),
    .soe_n    (soe_n),
    .xfer_cyc (xfer_cyc),
    .par_hiz  (par_hiz)
  );
endmodule

// File: rtl/vxfer_seq_chk.sv
`timescale 1ns/1ps
module vxfer_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic req_ready,
  input logic xfer_done,
  input logic ras_n,
  input logic cas_n,
  input logic dtoe_n,
  input logic we_n,
  input logic soe_n,
  input logic xfer_cyc,
  input logic par_hiz,
  input logic ser_out
);
  a_r2_cas_inside_ras: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_n |-> !ras_n);
  a_r8_dtoe_masked: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_n |-> !dtoe_n);
  a_r3_soe_in_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    !soe_n |-> xfer_cyc);
  a_r4_hiz_read_only: assert property (@(posedge clk) disable iff (!rst_n)
    par_hiz |-> (!soe_n && we_n));
  a_r9_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (ras_n && cas_n && !xfer_cyc));
  a_r9_done_then_ready: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> req_ready);
  a_r5_dir_at_cas_end: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_out != $past(ser_out)) |-> !$past(cas_n));
endmodule

bind vxfer_seq vxfer_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .xfer_done(xfer_done),
  .ras_n(ras_n), .cas_n(cas_n), .dtoe_n(dtoe_n), .we_n(we_n), .soe_n(soe_n),
  .xfer_cyc(xfer_cyc), .par_hiz(par_hiz), .ser_out(ser_out)
);

// File: tb/vxfer_seq_test.sv
`timescale 1ns/1ps
module vxfer_seq_test;
  localparam int TS = 2, TR = 3, TC = 3, TP = 4;
  localparam int ACT = TS + TR + TC;
  localparam int CYC = ACT + TP;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, win_req = 1'b0;
  logic req_ready, xfer_done, ras_n, cas_n, dtoe_n, we_n, soe_n;
  logic xfer_cyc, par_hiz, ser_out;

  int total = 0, bad = 0;
  int n_cyc, n_ras, n_cas, n_soe, n_soe_first, n_we, n_hiz, n_xq;
  int n_fall, n_order, n_win, n_ready;

  always #2 clk = ~clk;

  vxfer_seq #(.T_SETUP(TS), .T_RCD(TR), .T_CAS(TC), .T_PRE(TP)) uut (.*);

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // samples every clock after acceptance until the done pulse
  task automatic watch(input bit wiggle);
    logic ras_prev = 1'b1, dt_prev = 1'b1;
    n_cyc = 0; n_ras = 0; n_cas = 0; n_soe = 0; n_soe_first = 0; n_we = 0;
    n_hiz = 0; n_xq = 0; n_fall = 0; n_order = 0; n_win = 0; n_ready = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (wiggle) win_req = $urandom_range(0, 1);
      #0.5;
      n_cyc++;
      if (!ras_n) n_ras++;
      if (!cas_n) n_cas++;
      if (!soe_n) n_soe++;
      if (!soe_n && n_fall < 2 && n_cyc <= CYC) n_soe_first++;
      if (!we_n) n_we++;
      if (par_hiz) n_hiz++;
      if (xfer_cyc) n_xq++;
      if (req_ready) n_ready++;
      if (ras_prev && !ras_n) begin
        n_fall++;
        if (dt_prev) n_order++;
      end
      if (dtoe_n != (xfer_cyc ? 1'b0 : !win_req)) n_win++;
      ras_prev = ras_n;
      dt_prev  = dtoe_n;
      if (xfer_done) break;
    end
  endtask

  task automatic issue(input bit wr, input bit wiggle);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_write = wr;
    @(posedge clk);
    #0.5;
    req_valid = 1'b0;
    watch(wiggle);
  endtask

  task automatic after_done(input string tag);
    @(negedge clk); #0.5;
    chk({tag, " R9 ready after done"}, req_ready, 1);
    chk({tag, " R9 done single pulse"}, xfer_done, 0);
  endtask

  task automatic t_reset;
    #0.5;
    chk("R1 ras_n", ras_n, 1);
    chk("R1 cas_n", cas_n, 1);
    chk("R1 we_n", we_n, 1);
    chk("R1 soe_n", soe_n, 1);
    chk("R1 xfer_cyc", xfer_cyc, 0);
    chk("R1 ser_out", ser_out, 0);
    chk("R1 ready", req_ready, 1);
    chk("R1 done", xfer_done, 0);
  endtask

  task automatic t_read_first;
    issue(1'b0, 1'b0);
    chk("R9 read span", n_cyc, CYC);
    chk("R2 ras low clocks", n_ras, TR + TC);
    chk("R2 cas low clocks", n_cas, TC);
    chk("R2 dtoe before ras", n_order, 0);
    chk("R7 read one cycle", n_fall, 1);
    chk("R3 read soe", n_soe, ACT);
    chk("R3 read we high", n_we, 0);
    chk("R4 hiz clocks", n_hiz, ACT);
    chk("R10 qualifier clocks", n_xq, ACT);
    chk("R8 window rule", n_win, 0);
    chk("R9 not ready busy", n_ready, 0);
    chk("R5 out after read", ser_out, 1);
    after_done("read");
  endtask

  task automatic t_write_after_read;
    issue(1'b1, 1'b0);
    chk("R6 span with pseudo", n_cyc, 2 * CYC);
    chk("R6 two row strobes", n_fall, 2);
    chk("R6 soe only real cycle", n_soe, ACT);
    chk("R6 pseudo soe high", n_soe_first, 0);
    chk("R3 write we clocks", n_we, 2 * ACT);
    chk("R4 no hiz on write", n_hiz, 0);
    chk("R10 qualifier both", n_xq, 2 * ACT);
    chk("R2 order both cycles", n_order, 0);
    chk("R9 not ready busy", n_ready, 0);
    chk("R5 in after write", ser_out, 0);
    after_done("wr_after_rd");
  endtask

  task automatic t_write_after_write;
    issue(1'b1, 1'b0);
    chk("R7 write one cycle", n_fall, 1);
    chk("R7 write span", n_cyc, CYC);
    chk("R3 write soe", n_soe, ACT);
    chk("R3 write we", n_we, ACT);
    chk("R5 stays in", ser_out, 0);
  endtask

  task automatic t_read_after_read;
    issue(1'b0, 1'b0);
    issue(1'b0, 1'b0);
    chk("R7 read after read", n_fall, 1);
    chk("R5 stays out", ser_out, 1);
  endtask

  task automatic t_window;
    issue(1'b0, 1'b1);
    chk("R8 window masked wiggle", n_win, 0);
    issue(1'b1, 1'b1);
    chk("R8 window masked pseudo", n_win, 0);
    win_req = 1'b1;
    @(negedge clk); #0.5;
    chk("R8 idle follows window", dtoe_n, 0);
    win_req = 1'b0;
    #0.5;
    chk("R8 idle window off", dtoe_n, 1);
  endtask

  task automatic t_pending;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0;
    @(posedge clk); #0.5;
    req_write = 1'b1;          // next request held pending
    watch(1'b0);
    chk("R9 first of held pair", n_cyc, CYC);
    chk("R9 held not taken early", n_ready, 0);
    @(negedge clk); #0.5;
    chk("R9 held request sees ready", req_ready, 1);
    @(posedge clk); #0.5;
    req_valid = 1'b0;
    watch(1'b0);
    chk("R6 held write gets pseudo", n_fall, 2);
    chk("R6 held write span", n_cyc, 2 * CYC);
  endtask

  initial begin
    #(4 * 150000);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #5;
    t_reset;
    @(negedge clk);
    rst_n = 1'b1;
    t_read_first;
    t_write_after_read;
    t_write_after_write;
    t_read_after_read;
    t_window;
    t_pending;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule